// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer ratio N and emits one single-cycle pulse per N input cycles. The ratio is not counted by one flat binary counter. A 16/17 dual-modulus prescaler is steered by a 4-bit swallow counter (A) and an 11-bit main counter (M). Each division cycle consists of M prescaler cycles. The first A of them last 17 input cycles and the rest last 16, so N = 16·M + A. Every integer ratio from 240 to 32767 can be reached, which makes the output step exactly one input period.

A new 15-bit ratio word arrives on a valid/ready stream. The word's bits [3:0] form A and bits [14:4] form M. An accepted word waits in a one-entry holding slot. It takes effect only when the division cycle in progress completes, so no cycle is ever cut short. While the slot is occupied, `ratio_ready` is low and further words are back-pressured: a word offered while ready is low is not taken. Words below the supported range are replaced by the minimum ratio and raise a fault flag. A test output toggles on every divider pulse, giving the divided frequency halved again.

Top module: `swallow_divider`

## Requirements
- R1: For an applied word w with 240 ≤ w ≤ 32767, consecutive `div_pulse` assertions are exactly w input cycles apart (N = 16·M + A, with A = w[3:0] and M = w[14:4]).
- R2: `div_pulse` is high for exactly one input cycle per division cycle.
- R3: The range ends and the 16/17 boundaries are exact: 240, 241, 255, 256, 257, 271 and 32767 each yield a period equal to the word.
- R4: A word accepted during a division cycle leaves that cycle's length unchanged. The first full cycle after the next pulse uses the new ratio.
- R5: A transfer happens when `ratio_valid` and `ratio_ready` are both high at a clock edge. `ratio_ready` is low from the cycle after a transfer until the pulse at which the held word is applied, and it is high again in that pulse's cycle. A word offered while `ratio_ready` is low is not taken and never affects the period.
- R6: An accepted word below 240 (this covers every word with M < A) sets `ratio_fault` from the next cycle and runs the divider at 240. An accepted word of 240 or more clears `ratio_fault`.
- R7: `div_half` inverts in the same cycle as each `div_pulse` and holds its value otherwise, so its period is 2·N.
- R8: A synchronous active-high `rst` drives `div_pulse`, `div_half` and `ratio_fault` to 0, sets `ratio_ready` to 1 and loads ratio 240. The first pulse follows 240 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_valid | input | 1 | Ratio word offered |
| ratio_ready | output | 1 | Holding slot free; a word can be taken |
| ratio_word | input | 15 | Ratio word: [3:0] swallow count A, [14:4] main count M |
| div_pulse | output | 1 | One-cycle pulse per division cycle |
| div_half | output | 1 | Toggles on every pulse (divided output / 2) |
| ratio_fault | output | 1 | Last accepted word was below the supported range |

## Verification
The assertions assume that reset is held for at least two cycles and is not reasserted between two pulses, because the period window check measures the spacing between pulses from a counter that reset clears. The fault and back-pressure properties assume that `ratio_word` is stable in the cycle of a transfer. The stimulus drives all inputs on the falling edge and offers each new word in the cycle right after a pulse, so a transfer never falls on a boundary edge. The stimulus keeps random valid words in the range 240 to 4095 so that the run stays short. It reaches the wide end with one directed 32767 and covers the fault path with random words below 240.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int SWALLOW_W_DEF = 4;
  localparam int MAIN_W_DEF    = 11;
  localparam int MIN_RATIO_DEF = 240;

  typedef enum logic {
    MOD_LOW  = 1'b0,   // prescaler divides by 2**SWALLOW_W
    MOD_HIGH = 1'b1    // prescaler divides by 2**SWALLOW_W + 1
  } psc_mode_e;
endpackage

// File: rtl/swdiv_ratio_stage.sv
module swdiv_ratio_stage #(
  parameter int A_W         = swdiv_pkg::SWALLOW_W_DEF,
  parameter int M_W         = swdiv_pkg::MAIN_W_DEF,
  parameter int MIN_RATIO   = swdiv_pkg::MIN_RATIO_DEF,
  parameter int RESET_RATIO = swdiv_pkg::MIN_RATIO_DEF,
  localparam int W          = A_W + M_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_word,
  input  logic           cycle_end,
  output logic [M_W-1:0] nxt_m,
  output logic [A_W-1:0] nxt_a,
  output logic           fault
);
  localparam logic [W-1:0] MIN_WORD = W'(MIN_RATIO);
  localparam logic [W-1:0] RST_WORD = W'(RESET_RATIO);

  logic [W-1:0] pend_word;
  logic         pend_full;
  logic [W-1:0] act_word;
  logic [W-1:0] load_word;
  logic         accept;
  logic         word_ok;
  logic [M_W-1:0] in_m;
  logic [A_W-1:0] in_a;

  assign in_ready = !pend_full;
  assign accept   = in_valid && in_ready;
  assign in_m     = in_word[W-1:A_W];
  assign in_a     = in_word[A_W-1:0];
  // the swallow count must not exceed the main count, and the ratio must be in range
  assign word_ok  = (in_word >= MIN_WORD) && (in_m >= M_W'(in_a));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_word <= RST_WORD;
      pend_full <= 1'b0;
      act_word  <= RST_WORD;
      fault     <= 1'b0;
    end else if (accept) begin
      pend_word <= word_ok ? in_word : MIN_WORD;
      pend_full <= 1'b1;
      fault     <= !word_ok;
    end else if (cycle_end && pend_full) begin
      act_word  <= pend_word;
      pend_full <= 1'b0;
    end
  end

  // look-ahead: the reload at a boundary sees the held word directly
  assign load_word = pend_full ? pend_word : act_word;
  assign nxt_m     = load_word[W-1:A_W];
  assign nxt_a     = load_word[A_W-1:0];
endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int A_W         = swdiv_pkg::SWALLOW_W_DEF,
  parameter bit RESET_LONG  = 1'b0,
  localparam int BASE       = 1 << A_W,
  localparam int PC_W       = A_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  swdiv_pkg::psc_mode_e next_mode,
  output logic                 psc_tick
);
  import swdiv_pkg::*;

  localparam logic [PC_W-1:0] LEN_LOW_M1  = PC_W'(BASE - 1);
  localparam logic [PC_W-1:0] LEN_HIGH_M1 = PC_W'(BASE);

  logic [PC_W-1:0] pc;

  assign psc_tick = (pc == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_LONG ? LEN_HIGH_M1 : LEN_LOW_M1;
    end else if (psc_tick) begin
      pc <= (next_mode == MOD_HIGH) ? LEN_HIGH_M1 : LEN_LOW_M1;
    end else begin
      pc <= pc - PC_W'(1);
    end
  end
endmodule

// File: rtl/swdiv_cycle_ctrl.sv
module swdiv_cycle_ctrl #(
  parameter int A_W         = swdiv_pkg::SWALLOW_W_DEF,
  parameter int M_W         = swdiv_pkg::MAIN_W_DEF,
  parameter int RESET_RATIO = swdiv_pkg::MIN_RATIO_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 psc_tick,
  input  logic [M_W-1:0]       load_m,
  input  logic [A_W-1:0]       load_a,
  output swdiv_pkg::psc_mode_e next_mode,
  output logic                 cycle_end
);
  import swdiv_pkg::*;

  localparam logic [M_W-1:0] RST_M = M_W'(RESET_RATIO >> A_W);
  localparam logic [A_W-1:0] RST_A = A_W'(RESET_RATIO % (1 << A_W));

  logic [M_W-1:0] m_rem;   // prescaler cycles left, including the current one
  logic [A_W-1:0] a_rem;   // long (+1) prescaler cycles left, including the current one
  logic [A_W-1:0] a_dec;

  assign cycle_end = psc_tick && (m_rem == M_W'(1));
  assign a_dec     = (a_rem != '0) ? a_rem - A_W'(1) : '0;

  always_comb begin
    if (cycle_end) next_mode = (load_a != '0) ? MOD_HIGH : MOD_LOW;
    else           next_mode = (a_dec  != '0) ? MOD_HIGH : MOD_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rem <= RST_M;
      a_rem <= RST_A;
    end else if (psc_tick) begin
      if (cycle_end) begin
        m_rem <= load_m;
        a_rem <= load_a;
      end else begin
        m_rem <= m_rem - M_W'(1);
        a_rem <= a_dec;
      end
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int A_W         = swdiv_pkg::SWALLOW_W_DEF,
  parameter int M_W         = swdiv_pkg::MAIN_W_DEF,
  parameter int MIN_RATIO   = swdiv_pkg::MIN_RATIO_DEF,
  parameter int RESET_RATIO = swdiv_pkg::MIN_RATIO_DEF,
  localparam int W          = A_W + M_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ratio_valid,
  output logic         ratio_ready,
  input  logic [W-1:0] ratio_word,
  output logic         div_pulse,
  output logic         div_half,
  output logic         ratio_fault
);
  import swdiv_pkg::*;

  localparam bit RESET_LONG = (RESET_RATIO % (1 << A_W)) != 0;

  logic [M_W-1:0] nxt_m;
  logic [A_W-1:0] nxt_a;
  logic           cycle_end;
  logic           psc_tick;
  psc_mode_e      next_mode;

  swdiv_ratio_stage #(
    .A_W(A_W), .M_W(M_W), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)
  ) ratio_i (
    .clk(clk), .rst(rst),
    .in_valid(ratio_valid), .in_ready(ratio_ready), .in_word(ratio_word),
    .cycle_end(cycle_end),
    .nxt_m(nxt_m), .nxt_a(nxt_a), .fault(ratio_fault)
  );

  swdiv_prescaler #(
    .A_W(A_W), .RESET_LONG(RESET_LONG)
  ) psc_i (
    .clk(clk), .rst(rst), .next_mode(next_mode), .psc_tick(psc_tick)
  );

  swdiv_cycle_ctrl #(
    .A_W(A_W), .M_W(M_W), .RESET_RATIO(RESET_RATIO)
  ) ctrl_i (
    .clk(clk), .rst(rst), .psc_tick(psc_tick),
    .load_m(nxt_m), .load_a(nxt_a),
    .next_mode(next_mode), .cycle_end(cycle_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_pulse <= 1'b0;
      div_half  <= 1'b0;
    end else begin
      div_pulse <= cycle_end;
      div_half  <= div_half ^ cycle_end;
    end
  end
endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker #(
  parameter int W         = 15,
  parameter int MIN_RATIO = swdiv_pkg::MIN_RATIO_DEF,
  localparam int MAX_RATIO = (1 << W) - 1,
  localparam int CW        = W + 1
) (
  input logic         clk,
  input logic         rst,
  input logic         ratio_valid,
  input logic         ratio_ready,
  input logic [W-1:0] ratio_word,
  input logic         div_pulse,
  input logic         div_half,
  input logic         ratio_fault
);
  logic [CW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (div_pulse) begin
      gap  <= CW'(1);
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap  <= gap + CW'(1);
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse); // R2
  AST_PERIOD_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && seen) |-> (gap >= CW'(MIN_RATIO) && gap <= CW'(MAX_RATIO))); // R1
  AST_HALF_FLIP: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (div_half != $past(div_half))); // R7
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !div_pulse |-> $stable(div_half)); // R7
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (ratio_valid && ratio_ready) |=> !ratio_ready); // R5
  AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
    (ratio_valid && ratio_ready && ratio_word < W'(MIN_RATIO)) |=> ratio_fault); // R6
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ratio_valid && ratio_ready && ratio_word >= W'(MIN_RATIO)) |=> !ratio_fault); // R6
  AST_FAULT_STEADY: assert property (@(posedge clk) disable iff (rst)
    !(ratio_valid && ratio_ready) |=> $stable(ratio_fault)); // R6
endmodule

bind swallow_divider swdiv_checker #(.W(W), .MIN_RATIO(MIN_RATIO)) chk_i (
  .clk(clk), .rst(rst), .ratio_valid(ratio_valid), .ratio_ready(ratio_ready),
  .ratio_word(ratio_word), .div_pulse(div_pulse), .div_half(div_half),
  .ratio_fault(ratio_fault)
);

// File: tb/swallow_divider_tb_top.sv
module swallow_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ratio_valid = 1'b0;
  logic        ratio_ready;
  logic [14:0] ratio_word = '0;
  logic        div_pulse;
  logic        div_half;
  logic        ratio_fault;

  int checks = 0;
  int errors = 0;
  int cur_period = 240;
  bit exp_half = 1'b0;

  always #5 clk = ~clk;

  swallow_divider dut_i (
    .clk(clk), .rst(rst), .ratio_valid(ratio_valid), .ratio_ready(ratio_ready),
    .ratio_word(ratio_word), .div_pulse(div_pulse), .div_half(div_half),
    .ratio_fault(ratio_fault)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_period(int w);
    return (w < 240) ? 240 : w;
  endfunction

  // advance on falling edges until a pulse is seen; n = samples taken
  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < 70000);
    exp_half = ~exp_half;
    chk(div_half == exp_half, "R7", "div_half at pulse", int'(div_half), int'(exp_half));
  endtask

  // called at a pulse sample; offers w, optionally pushes an intruder word while blocked
  task automatic load_and_measure(int w, string req, int intruder = -1);
    int n, m;
    ratio_valid = 1'b1;
    ratio_word  = 15'(w);
    @(negedge clk);
    ratio_valid = 1'b0;
    n = 1;
    chk(div_pulse == 1'b0, "R2", "pulse width", int'(div_pulse), 0);
    chk(ratio_ready == 1'b0, "R5", "ready after transfer", int'(ratio_ready), 0);
    chk(ratio_fault == (w < 240), "R6", "fault after transfer", int'(ratio_fault), int'(w < 240));
    if (intruder >= 0) begin
      ratio_valid = 1'b1;
      ratio_word  = 15'(intruder);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        n++;
        chk(ratio_ready == 1'b0, "R5", "ready held low", int'(ratio_ready), 0);
      end
      ratio_valid = 1'b0;
    end
    wait_pulse(m);
    chk(n + m == cur_period, "R4", "cycle in progress keeps old ratio", n + m, cur_period);
    chk(ratio_ready == 1'b1, "R5", "ready back at boundary", int'(ratio_ready), 1);
    wait_pulse(m);
    chk(m == exp_period(w), req, "period for new word", m, exp_period(w));
    cur_period = exp_period(w);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0451));
    repeat (5) @(negedge clk);
    chk(div_pulse == 1'b0, "R8", "reset pulse", int'(div_pulse), 0);
    chk(div_half == 1'b0, "R8", "reset half", int'(div_half), 0);
    chk(ratio_fault == 1'b0, "R8", "reset fault", int'(ratio_fault), 0);
    chk(ratio_ready == 1'b1, "R8", "reset ready", int'(ratio_ready), 1);
    rst = 1'b0;
    wait_pulse(n);
    chk(n == 240, "R8", "first pulse after reset", n, 240);
    wait_pulse(n);
    chk(n == 240, "R1", "reset ratio period", n, 240);

    // R3 directed boundaries around the 16/17 split and range ends
    load_and_measure(241, "R3");
    load_and_measure(255, "R3");
    load_and_measure(256, "R3");
    load_and_measure(257, "R3");
    load_and_measure(271, "R3");
    load_and_measure(32767, "R3");
    load_and_measure(240, "R3");

    // R6 below-range words clamp to 240 and raise the fault
    load_and_measure(239, "R6");
    load_and_measure(0, "R6");
    load_and_measure(1000, "R6");
    chk(ratio_fault == 1'b0, "R6", "fault cleared by valid word", int'(ratio_fault), 0);

    // R5 a word offered while blocked is not taken
    load_and_measure(777, "R5", 5000);
    load_and_measure(613, "R5");

    // R1 random ratios in range
    for (int i = 0; i < 8; i++) begin
      load_and_measure(int'($urandom_range(4095, 240)), "R1");
    end
    // R6 random below-range word
    load_and_measure(int'($urandom_range(239, 0)), "R6");
    load_and_measure(int'($urandom_range(2000, 240)), "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule